// File: doc/BRIEF.md
# Converter Channel Host Register File

This block is the host-facing register front end of a data converter's command/response channel. A processor reaches it over a simple 32-bit bus with separate read and write strobes and byte addresses on word boundaries. It holds a configuration word, an interrupt status word, an interrupt mask and a misc-control word. It also builds a live status word from the level of the response FIFO. Command words and response reads pass straight through to a command engine over a push/pop side interface.

Commands are taken by the engine as soon as they are pushed, so the command queue always reports itself empty and below threshold. Two interrupt causes can latch in the status word: command queue below threshold, which is always true, and response FIFO above threshold, which holds while the FIFO level exceeds a threshold set in the configuration word. Software clears status bits by writing ones to them. A single level interrupt output is the OR of the unmasked status bits.

Top module: `adc_host_regs`

## Requirements
- R1: After reset the config word (0x00) reads 0x00001814, status (0x04) reads 0x00000200, mask (0x08) reads 0xFFFFFFFF, misc control (0x18) reads 0x00000010, and `irq` is low.
- R2: A write to config is stored whole. A write to misc control is stored ANDed with 0x00FFFEFF. Both read back the stored value.
- R3: A write to the mask (0x08) keeps only bits 9:0. All other bits read back as 0.
- R4: Writing the status word clears each bit where the data is 1. Bit 9 is forced back to 1 on every cycle, so it always reads 1.
- R5: Status bit 8 is set whenever the response FIFO level is greater than config bits 19:16. It stays set until it is cleared by a write, and a clear has no effect while the condition still holds.
- R6: `irq` equals the OR of (status AND NOT mask[9:0]). It reflects a register write from the cycle after that write.
- R7: A read of misc status (0x0C) returns bit 10 = 1, the FIFO level in bits 15:12, bit 8 = 1 when the level is 0, and bit 9 = 1 when the level equals DEPTH. All other bits are 0.
- R8: A read of 0x14 raises `rd_pop` for that cycle and returns `eng_head` in bits 15:0 of the same response, with the upper bits 0. No other access raises `rd_pop`.
- R9: A write to 0x10 raises `cmd_push` for that cycle with `cmd_data` equal to the written word, but only when misc-control bit 4 is 0. Otherwise the command is dropped.
- R10: A read of 0x10, or of any address outside the seven word offsets, returns 0. A write to 0x0C, to 0x14 or to an unmapped address changes no register and raises no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_rdata | output | 32 | Read data, valid in the strobe cycle |
| cmd_push | output | 1 | Command word push to the engine |
| cmd_data | output | 32 | Command word |
| rd_pop | output | 1 | Response FIFO pop to the engine |
| eng_head | input | 16 | Head entry of the response FIFO |
| dfifo_level | input | LVL_W | Response FIFO entry count, 0 to DEPTH |
| irq | output | 1 | Level interrupt |

## Verification
The assertions assume that `bus_rd` and `bus_wr` are never high in the same cycle. They also assume that `dfifo_level` never exceeds DEPTH. The stimulus drives at most one strobe per transfer, with a gap cycle after it, and only sweeps the level across 0 to DEPTH. The level and head inputs change only at the falling clock edge, so they are stable across every rising edge.

// File: rtl/adc_host_regs.sv
module adc_host_regs #(
  parameter int ADDR_W = 8,
  parameter int DEPTH  = 15,
  parameter int LVL_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_rd,
  output logic [31:0]       bus_rdata,
  output logic              cmd_push,
  output logic [31:0]       cmd_data,
  output logic              rd_pop,
  input  logic [15:0]       eng_head,
  input  logic [LVL_W-1:0]  dfifo_level,
  output logic              irq
);
  localparam logic [31:0] CFG_RST   = 32'h0000_1814;
  localparam logic [31:0] MCTL_RST  = 32'h0000_0010;
  localparam logic [31:0] MCTL_KEEP = 32'h00FF_FEFF;
  localparam logic [9:0]  STS_RST   = 10'h200;

  logic [31:0] cfg_q, mask_q, mctl_q;
  logic [9:0]  sts_q, sts_clr;
  logic        gth;

  wire a_cfg  = bus_addr == ADDR_W'(8'h00);
  wire a_sts  = bus_addr == ADDR_W'(8'h04);
  wire a_mask = bus_addr == ADDR_W'(8'h08);
  wire a_msts = bus_addr == ADDR_W'(8'h0C);
  wire a_cmd  = bus_addr == ADDR_W'(8'h10);
  wire a_rdf  = bus_addr == ADDR_W'(8'h14);
  wire a_mctl = bus_addr == ADDR_W'(8'h18);

  assign gth      = 32'(dfifo_level) > 32'(cfg_q[19:16]);
  assign sts_clr  = (bus_wr && a_sts) ? bus_wdata[9:0] : 10'h0;
  assign cmd_push = bus_wr && a_cmd && !mctl_q[4];
  assign cmd_data = bus_wdata;
  assign rd_pop   = bus_rd && a_rdf;
  assign irq      = |(sts_q & ~mask_q[9:0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= CFG_RST;
      mask_q <= '1;
      mctl_q <= MCTL_RST;
      sts_q  <= STS_RST;
    end else begin
      if (bus_wr && a_cfg)  cfg_q  <= bus_wdata;
      if (bus_wr && a_mask) mask_q <= {22'h0, bus_wdata[9:0]};
      if (bus_wr && a_mctl) mctl_q <= bus_wdata & MCTL_KEEP;
      sts_q <= (sts_q & ~sts_clr) | STS_RST | {1'b0, gth, 8'h0};
    end
  end

  always_comb begin
    bus_rdata = 32'h0;
    if (bus_rd) begin
      if (a_cfg)  bus_rdata = cfg_q;
      if (a_sts)  bus_rdata = {22'h0, sts_q};
      if (a_mask) bus_rdata = mask_q;
      if (a_mctl) bus_rdata = mctl_q;
      if (a_rdf)  bus_rdata = {16'h0, eng_head};
      if (a_msts) begin
        bus_rdata        = 32'h0000_0400;
        bus_rdata[15:12] = 4'(dfifo_level);
        bus_rdata[8]     = dfifo_level == '0;
        bus_rdata[9]     = 32'(dfifo_level) == DEPTH;
      end
    end
  end
endmodule

// File: rtl/adc_host_regs_chk.sv
module adc_host_regs_chk #(
  parameter int ADDR_W = 8,
  parameter int LVL_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic [31:0]       bus_wdata,
  input logic              bus_rd,
  input logic [31:0]       bus_rdata,
  input logic              cmd_push,
  input logic [31:0]       cmd_data,
  input logic              rd_pop,
  input logic [15:0]       eng_head,
  input logic [LVL_W-1:0]  dfifo_level,
  input logic              irq
);
  // R8
  pop_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_pop |-> (bus_rd && bus_rdata == {16'h0, eng_head}));
  // R9
  push_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_push |-> (bus_wr && cmd_data == bus_wdata && bus_addr == ADDR_W'(8'h10)));
  // R4
  sts_bit9_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == ADDR_W'(8'h04)) |-> bus_rdata[9]);
  // R7
  msts_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == ADDR_W'(8'h0C)) |-> (bus_rdata[10] && bus_rdata[15:12] == 4'(dfifo_level)));
  // R6
  mask_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(8'h08) && bus_wdata[9:0] == 10'h3FF) |=> !irq);
  // R10
  cmd_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == ADDR_W'(8'h10)) |-> (bus_rdata == 32'h0 && !rd_pop));
endmodule

bind adc_host_regs adc_host_regs_chk #(.ADDR_W(ADDR_W), .LVL_W(LVL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
  .cmd_push(cmd_push), .cmd_data(cmd_data), .rd_pop(rd_pop),
  .eng_head(eng_head), .dfifo_level(dfifo_level), .irq(irq));

// File: tb/test_adc_host_regs.sv
module test_adc_host_regs;
  localparam int DEPTH = 15;
  logic clk = 0, rst_n = 0;
  logic [7:0] bus_addr = 0;
  logic bus_wr = 0, bus_rd = 0;
  logic [31:0] bus_wdata = 0;
  logic [31:0] bus_rdata, cmd_data;
  logic cmd_push, rd_pop, irq;
  logic [15:0] eng_head = 0;
  logic [3:0] dfifo_level = 0;
  int checks = 0, fails = 0;
  bit done = 0;
  logic [31:0] rv;

  always #10 clk = ~clk;

  adc_host_regs i_adc_host_regs (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1;
    #5 d = bus_rdata;
    @(negedge clk); bus_rd = 0;
  endtask

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    logic [31:0] pat [6];
    pat = '{32'h0, 32'hFFFFFFFF, 32'hA5A5A5A5, 32'h5A5A5A5A, 32'h00000100, 32'h12345678};
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd(8'h00, rv); chk("R1 cfg", rv, 32'h00001814);
    rd(8'h04, rv); chk("R1 sts", rv, 32'h200);
    rd(8'h08, rv); chk("R1 mask", rv, 32'hFFFFFFFF);
    rd(8'h18, rv); chk("R1 mctl", rv, 32'h10);
    chk("R1 irq", {31'h0, irq}, 0);
    // R9 command dropped while channel reset bit set
    @(negedge clk); bus_addr = 8'h10; bus_wdata = 32'hCAFE0001; bus_wr = 1;
    #5 chk("R9 push blocked", {31'h0, cmd_push}, 0);
    @(negedge clk); bus_wr = 0;
    // R2 / R3 patterns
    foreach (pat[i]) begin
      wr(8'h18, pat[i]); rd(8'h18, rv); chk("R2 mctl", rv, pat[i] & 32'h00FFFEFF);
      wr(8'h08, pat[i]); rd(8'h08, rv); chk("R3 mask", rv, pat[i] & 32'h3FF);
      wr(8'h00, pat[i]); rd(8'h00, rv); chk("R2 cfg", rv, pat[i]);
    end
    wr(8'h18, 0);
    // R9 push with data
    @(negedge clk); bus_addr = 8'h10; bus_wdata = 32'h0801_BEEF; bus_wr = 1;
    #5 chk("R9 push", {31'h0, cmd_push}, 1); chk("R9 data", cmd_data, 32'h0801_BEEF);
    @(negedge clk); bus_wr = 0;
    // R4 clear all, bit 9 re-set
    dfifo_level = 0;
    wr(8'h04, 32'hFFFFFFFF); rd(8'h04, rv); chk("R4 w1c", rv, 32'h200);
    // R6 bit 9 unmasked
    wr(8'h08, 32'h1FF); chk("R6 irq bit9", {31'h0, irq}, 1);
    wr(8'h08, 32'h3FF); chk("R6 masked", {31'h0, irq}, 0);
    // R5 / R6 threshold sweep
    for (int t = 0; t < 16; t++) begin
      wr(8'h00, 32'(t) << 16);
      wr(8'h08, 32'h2FF);
      for (int l = 0; l <= DEPTH; l++) begin
        @(negedge clk); dfifo_level = 4'(l);
        wr(8'h04, 32'h100);
        rd(8'h04, rv);
        chk("R5 gth", rv, 32'h200 | ((l > t) ? 32'h100 : 32'h0));
        chk("R6 irq", {31'h0, irq}, (l > t) ? 1 : 0);
      end
    end
    // R5 sticky after level drops
    wr(8'h00, 32'h0); @(negedge clk); dfifo_level = 5;
    @(negedge clk); dfifo_level = 0;
    rd(8'h04, rv); chk("R5 sticky", rv, 32'h300);
    wr(8'h04, 32'h100); rd(8'h04, rv); chk("R5 cleared", rv, 32'h200);
    // R7 status sweep
    for (int l = 0; l <= DEPTH; l++) begin
      @(negedge clk); dfifo_level = 4'(l);
      rd(8'h0C, rv);
      chk("R7 msts", rv, 32'h400 | (32'(l) << 12) | ((l == 0) ? 32'h100 : 0) | ((l == DEPTH) ? 32'h200 : 0));
    end
    // R8 pop
    foreach (pat[i]) begin
      @(negedge clk); eng_head = pat[i][15:0]; bus_addr = 8'h14; bus_rd = 1;
      #5 chk("R8 pop", {31'h0, rd_pop}, 1); chk("R8 head", bus_rdata, {16'h0, pat[i][15:0]});
      @(negedge clk); bus_rd = 0;
      #5 chk("R8 pop low", {31'h0, rd_pop}, 0);
    end
    // R10 disallowed
    rd(8'h10, rv); chk("R10 cmd read", rv, 0);
    rd(8'h1C, rv); chk("R10 unmapped", rv, 0);
    rd(8'h02, rv); chk("R10 unaligned", rv, 0);
    wr(8'h00, 32'h1111_2222); wr(8'h18, 32'h33);
    @(negedge clk); bus_addr = 8'h14; bus_wdata = 32'hFFFFFFFF; bus_wr = 1;
    #5 chk("R10 no pop on write", {31'h0, rd_pop}, 0);
    @(negedge clk); bus_wr = 0;
    wr(8'h0C, 32'hFFFFFFFF); wr(8'h1C, 32'hFFFFFFFF); wr(8'h20, 32'hFFFFFFFF);
    rd(8'h00, rv); chk("R10 cfg kept", rv, 32'h1111_2222);
    rd(8'h18, rv); chk("R10 mctl kept", rv, 32'h33);
    rd(8'h08, rv); chk("R10 mask kept", rv, 32'h2FF);
    done = 1;
    summary();
  end
endmodule